// File: doc/BRIEF.md
# Dual Maskable Time Alarm Unit

This block watches the current BCD time of a real-time clock and raises alarms when it matches one of two programmed alarm settings. The comparison runs only in the cycle where the timekeeper's once-per-second update strobe is high. The first alarm compares seconds, minutes, hours and a day/date field. The second alarm compares minutes, hours and a day/date field, and can only fire on an update whose seconds value is 00.

Each alarm field byte holds a mask bit. A masked field is left out of the compare, so the alarm repeats every second, minute, hour, day or date. Each day/date byte also holds a select bit that picks either the day of the week or the date of the month as the compare target. A match sets a sticky flag for that alarm, and the flag stays set until the host pulses a clear. The flags, gated by per-alarm interrupt enables, drive two active-low interrupt pins. A routing input either merges both alarms onto the first pin or gives each alarm its own pin.

Top module: `dual_alarm_unit`

## Requirements
- R1: While reset is asserted and right after it, both flags read 0 and both interrupt pins read 1.
- R2: With no field masked, alarm 1 sets its flag on an update strobe only when seconds, minutes, hours and the day/date target all equal the alarm bytes in bits 6:0 (bits 5:0 for day/date). The flag is visible in the cycle after the strobe.
- R3: Bit 7 of any alarm field byte set to 1 drops that field from the compare. With all four fields masked, alarm 1 fires on every update.
- R4: Bit 6 of a day/date alarm byte selects the target: 0 compares bits 5:0 with the date of month, and 1 compares them with the day of week.
- R5: Alarm 2 sets its flag only on an update whose seconds input is 8'h00. With its three fields masked, it fires once per minute.
- R6: With the update strobe low, no flag goes from 0 to 1, even while the time matches.
- R7: A flag stays 1 until its clear input is pulsed. A clear in the same cycle as a matching update leaves the flag at 1.
- R8: An alarm requests an interrupt when its flag and its enable are both 1. The pins are active low and change one cycle after their inputs.
- R9: Routing input 0 drives the first pin low for a request from either alarm and holds the second pin at 1. Routing input 1 puts alarm 1 on the first pin and alarm 2 on the second.
- R10: The hours compare includes bit 6 (12/24 mode) and bit 5 (PM or 20-hour digit), so a value of 12-hour 8 PM does not match 12-hour 8 AM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | Once-per-second time update strobe |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours byte, including the mode and AM/PM bits |
| now_wday | input | 8 | Current day of week |
| now_date | input | 8 | Current date of month, BCD |
| al1_sec | input | 8 | Alarm 1 seconds byte, bit 7 is the mask |
| al1_min | input | 8 | Alarm 1 minutes byte, bit 7 is the mask |
| al1_hour | input | 8 | Alarm 1 hours byte, bit 7 is the mask |
| al1_daydate | input | 8 | Alarm 1 day/date byte: bit 7 mask, bit 6 select, bits 5:0 value |
| al2_min | input | 8 | Alarm 2 minutes byte, bit 7 is the mask |
| al2_hour | input | 8 | Alarm 2 hours byte, bit 7 is the mask |
| al2_daydate | input | 8 | Alarm 2 day/date byte: bit 7 mask, bit 6 select, bits 5:0 value |
| al1_int_en | input | 1 | Alarm 1 interrupt enable |
| al2_int_en | input | 1 | Alarm 2 interrupt enable |
| int_split | input | 1 | 0: both alarms on irq_a_n; 1: one pin per alarm |
| al1_clear | input | 1 | Pulse to clear the alarm 1 flag |
| al2_clear | input | 1 | Pulse to clear the alarm 2 flag |
| al1_flag | output | 1 | Alarm 1 flag |
| al2_flag | output | 1 | Alarm 2 flag |
| irq_a_n | output | 1 | First interrupt pin, active low |
| irq_b_n | output | 1 | Second interrupt pin, active low |

## Verification
The assertions check, on every cycle, the temporal rules of the flags and pins. A matching update sets a flag, a flag never rises without an update, a flag holds until a clear, a clear without an update drops the flag, alarm 2 rises only after a 00-seconds update, and the pins follow the gated flags one cycle later in both routing modes. Which field patterns count as a match cannot be shown that way. Only the bench's scenarios can show it: single and full masking, the day-of-week and date selection, the seconds-00 rule of alarm 2, the 12/24 and PM bits in the hours compare, and a clear that collides with a matching update.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
package alm_pkg;
  localparam int unsigned FW         = 8;
  localparam int unsigned MASK_POS   = FW - 1;
  localparam int unsigned SEL_POS    = FW - 2;
  localparam int unsigned N_FIELDS   = 4;
  localparam int unsigned NUM_ALARMS = 2;
  typedef logic [FW-1:0] bcd_t;
endpackage

// File: rtl/alm_rst_sync.sv
`timescale 1ns/1ps
module alm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/alm_field_cmp.sv
`timescale 1ns/1ps
module alm_field_cmp
  import alm_pkg::*;
#(
  parameter bit IS_DAYDATE = 1'b0
) (
  input  bcd_t alarm_i,
  input  bcd_t cur_i,
  input  bcd_t alt_i,
  output logic hit_o
);
  localparam int unsigned VAL_BITS = IS_DAYDATE ? SEL_POS : MASK_POS;
  localparam bcd_t        VAL_MASK = bcd_t'((1 << VAL_BITS) - 1);

  logic use_alt;
  bcd_t target;

  always_comb begin
    use_alt = IS_DAYDATE && alarm_i[SEL_POS];
    target  = use_alt ? alt_i : cur_i;
    hit_o   = alarm_i[MASK_POS] || (((alarm_i ^ target) & VAL_MASK) == '0);
  end
endmodule

// File: rtl/alm_channel.sv
`timescale 1ns/1ps
module alm_channel
  import alm_pkg::*;
#(
  parameter int unsigned NF = N_FIELDS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic            clr_i,
  input  bcd_t [NF-1:0]   alarm_i,
  input  bcd_t [NF-1:0]   cur_i,
  input  bcd_t            alt_i,
  output logic            flag_o
);
  logic [NF-1:0] hit;
  logic          hit_all;
  logic          set_hit;
  logic          flag_en;
  logic          flag_d;
  logic          flag_q;

  for (genvar g = 0; g < NF; g++) begin : g_field
    alm_field_cmp #(.IS_DAYDATE(g == NF - 1)) u_cmp (
      .alarm_i (alarm_i[g]),
      .cur_i   (cur_i[g]),
      .alt_i   (alt_i),
      .hit_o   (hit[g])
    );
  end

  always_comb begin
    hit_all = &hit;
    set_hit = tick_i && hit_all;
    flag_en = clr_i || set_hit;
    flag_d  = set_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_set_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && hit_all) |=> flag_q);
  assert_no_set_without_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !tick_i) |=> !flag_q);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !tick_i) |=> !flag_q);
endmodule

// File: rtl/alm_irq_route.sv
`timescale 1ns/1ps
module alm_irq_route
  import alm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] flag_i,
  input  logic [NUM_ALARMS-1:0] ie_i,
  input  logic                  split_i,
  output logic                  irq_a_n,
  output logic                  irq_b_n
);
  logic [NUM_ALARMS-1:0] req;
  logic                  a_d, b_d;
  logic                  a_q, b_q;

  always_comb begin
    req = flag_i & ie_i;
    if (split_i) begin
      a_d = ~req[0];
      b_d = ~req[1];
    end else begin
      a_d = ~|req;
      b_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b1;
      b_q <= 1'b1;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign irq_a_n = a_q;
  assign irq_b_n = b_q;

  assert_alarm1_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_i[0] && ie_i[0]) |=> !irq_a_n);
  assert_no_request_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(flag_i[0] && ie_i[0]) && !(flag_i[1] && ie_i[1])) |=> (irq_a_n && irq_b_n));
  assert_shared_b_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !split_i |=> irq_b_n);
  assert_split_b_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (split_i && flag_i[1] && ie_i[1]) |=> !irq_b_n);
endmodule

// File: rtl/dual_alarm_unit.sv
`timescale 1ns/1ps
module dual_alarm_unit
  import alm_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic sec_tick,
  input  logic [7:0] now_sec,
  input  logic [7:0] now_min,
  input  logic [7:0] now_hour,
  input  logic [7:0] now_wday,
  input  logic [7:0] now_date,
  input  logic [7:0] al1_sec,
  input  logic [7:0] al1_min,
  input  logic [7:0] al1_hour,
  input  logic [7:0] al1_daydate,
  input  logic [7:0] al2_min,
  input  logic [7:0] al2_hour,
  input  logic [7:0] al2_daydate,
  input  logic al1_int_en,
  input  logic al2_int_en,
  input  logic int_split,
  input  logic al1_clear,
  input  logic al2_clear,
  output logic al1_flag,
  output logic al2_flag,
  output logic irq_a_n,
  output logic irq_b_n
);
  localparam bcd_t A2_SEC_FIXED = '0;

  logic                                 rst_n_s;
  bcd_t [N_FIELDS-1:0]                  now_fields;
  bcd_t [NUM_ALARMS-1:0][N_FIELDS-1:0]  alarm_set;
  logic [NUM_ALARMS-1:0]                clear_v;
  logic [NUM_ALARMS-1:0]                flag_v;
  logic [NUM_ALARMS-1:0]                ie_v;

  alm_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_n_sync (rst_n_s)
  );

  assign now_fields   = {now_date, now_hour, now_min, now_sec};
  assign alarm_set[0] = {al1_daydate, al1_hour, al1_min, al1_sec};
  assign alarm_set[1] = {al2_daydate, al2_hour, al2_min, A2_SEC_FIXED};
  assign clear_v      = {al2_clear, al1_clear};
  assign ie_v         = {al2_int_en, al1_int_en};

  for (genvar c = 0; c < NUM_ALARMS; c++) begin : g_ch
    alm_channel #(.NF(N_FIELDS)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .tick_i  (sec_tick),
      .clr_i   (clear_v[c]),
      .alarm_i (alarm_set[c]),
      .cur_i   (now_fields),
      .alt_i   (now_wday),
      .flag_o  (flag_v[c])
    );
  end

  alm_irq_route u_route (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .flag_i  (flag_v),
    .ie_i    (ie_v),
    .split_i (int_split),
    .irq_a_n (irq_a_n),
    .irq_b_n (irq_b_n)
  );

  assign al1_flag = flag_v[0];
  assign al2_flag = flag_v[1];

  assert_a2_zero_seconds_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(al2_flag) |-> ($past(now_sec) == 8'h00 && $past(sec_tick)));
endmodule

// File: tb/dual_alarm_unit_tb.sv
`timescale 1ns/1ps
module dual_alarm_unit_tb;
  logic clk = 1'b0;
  logic arst_n;
  logic sec_tick;
  logic [7:0] now_sec, now_min, now_hour, now_wday, now_date;
  logic [7:0] al1_sec, al1_min, al1_hour, al1_daydate;
  logic [7:0] al2_min, al2_hour, al2_daydate;
  logic al1_int_en, al2_int_en, int_split, al1_clear, al2_clear;
  logic al1_flag, al2_flag, irq_a_n, irq_b_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  bit e1 = 1'b0;
  bit e2 = 1'b0;

  typedef struct {
    logic  f1, f2, ia, ib;
    string req;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  dual_alarm_unit u_dut (
    .clk(clk), .arst_n(arst_n), .sec_tick(sec_tick),
    .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour),
    .now_wday(now_wday), .now_date(now_date),
    .al1_sec(al1_sec), .al1_min(al1_min), .al1_hour(al1_hour), .al1_daydate(al1_daydate),
    .al2_min(al2_min), .al2_hour(al2_hour), .al2_daydate(al2_daydate),
    .al1_int_en(al1_int_en), .al2_int_en(al2_int_en), .int_split(int_split),
    .al1_clear(al1_clear), .al2_clear(al2_clear),
    .al1_flag(al1_flag), .al2_flag(al2_flag), .irq_a_n(irq_a_n), .irq_b_n(irq_b_n)
  );

  // Driver side: expected pins follow R8/R9 from the modelled flags.
  task automatic expect_now(input string req);
    exp_t x;
    logic r1, r2;
    r1 = e1 & al1_int_en;
    r2 = e2 & al2_int_en;
    x.f1 = e1;
    x.f2 = e2;
    x.ia = int_split ? ~r1 : ~(r1 | r2);
    x.ib = int_split ? ~r2 : 1'b1;
    x.req = req;
    sb_q.push_back(x);
  endtask

  task automatic do_tick();
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic clear_one(input int which);
    if (which == 1) al1_clear = 1'b1; else al2_clear = 1'b1;
    @(negedge clk);
    al1_clear = 1'b0;
    al2_clear = 1'b0;
    @(negedge clk);
    if (which == 1) e1 = 1'b0; else e2 = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_now(input logic [7:0] s, m, h, w, d);
    now_sec = s; now_min = m; now_hour = h; now_wday = w; now_date = d;
  endtask

  task automatic set_a1(input logic [7:0] s, m, h, dd);
    al1_sec = s; al1_min = m; al1_hour = h; al1_daydate = dd;
  endtask

  // Monitor side: pops and compares after the outputs have settled.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t x;
        x = sb_q.pop_front();
        checks++;
        if ({al1_flag, al2_flag, irq_a_n, irq_b_n} !== {x.f1, x.f2, x.ia, x.ib}) begin
          errors++;
          $display("FAIL %s: got flags=%b%b irq=%b%b expected flags=%b%b irq=%b%b",
                   x.req, al1_flag, al2_flag, irq_a_n, irq_b_n, x.f1, x.f2, x.ia, x.ib);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got no completion, expected end of test");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0;
    sec_tick = 1'b0;
    al1_clear = 1'b0; al2_clear = 1'b0;
    al1_int_en = 1'b0; al2_int_en = 1'b0; int_split = 1'b0;
    set_now(8'h29, 8'h15, 8'h08, 8'h01, 8'h12);
    set_a1(8'h59, 8'h59, 8'h23, 8'h31);
    al2_min = 8'h59; al2_hour = 8'h23; al2_daydate = 8'h31;
    idle(2);
    expect_now("R1 during reset");
    arst_n = 1'b1;
    idle(4);
    expect_now("R1 after reset");

    // R2: full match on alarm 1
    set_a1(8'h30, 8'h15, 8'h08, 8'h12);
    do_tick(); expect_now("R2 seconds differ");
    now_sec = 8'h30;
    do_tick(); e1 = 1'b1; expect_now("R2 full match");

    // R7 clear, then R6 no strobe while matching
    clear_one(1); expect_now("R7 clear");
    idle(3); expect_now("R6 no tick keeps flag low");

    // R7 sticky and set-over-clear
    do_tick(); e1 = 1'b1; expect_now("R2 match again");
    now_sec = 8'h31;
    do_tick(); expect_now("R7 sticky after mismatch");
    now_sec = 8'h30;
    sec_tick = 1'b1; al1_clear = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0; al1_clear = 1'b0;
    @(negedge clk);
    expect_now("R7 set wins over clear");
    clear_one(1); expect_now("R7 clear after collision");

    // R3 masks
    set_a1(8'h80, 8'h15, 8'h08, 8'h12);
    now_sec = 8'h45;
    do_tick(); e1 = 1'b1; expect_now("R3 seconds masked");
    clear_one(1);
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    set_now(8'h07, 8'h44, 8'h17, 8'h05, 8'h27);
    do_tick(); e1 = 1'b1; expect_now("R3 all masked");
    clear_one(1); expect_now("R3 cleared");

    // R4 day/date select
    set_a1(8'h80, 8'h80, 8'h80, 8'h43);
    set_now(8'h07, 8'h44, 8'h17, 8'h03, 8'h12);
    do_tick(); e1 = 1'b1; expect_now("R4 day of week match");
    clear_one(1);
    now_wday = 8'h04;
    do_tick(); expect_now("R4 day of week mismatch");
    al1_daydate = 8'h03;
    now_wday = 8'h03;
    do_tick(); expect_now("R4 date target ignores weekday");
    now_date = 8'h03;
    do_tick(); e1 = 1'b1; expect_now("R4 date match");
    clear_one(1);

    // R10 hours byte with mode and PM bits
    set_a1(8'h80, 8'h80, 8'h68, 8'hC0);
    now_hour = 8'h48;
    do_tick(); expect_now("R10 AM vs PM");
    now_hour = 8'h08;
    do_tick(); expect_now("R10 24h vs 12h");
    now_hour = 8'h68;
    do_tick(); e1 = 1'b1; expect_now("R10 PM match");
    clear_one(1);

    // R5 alarm 2
    set_a1(8'h59, 8'h59, 8'h23, 8'h31);
    al2_min = 8'h80; al2_hour = 8'h80; al2_daydate = 8'h80;
    set_now(8'h01, 8'h15, 8'h08, 8'h02, 8'h12);
    do_tick(); expect_now("R5 seconds not zero");
    now_sec = 8'h00;
    do_tick(); e2 = 1'b1; expect_now("R5 once per minute");
    clear_one(2);
    al2_min = 8'h15; al2_hour = 8'h08; al2_daydate = 8'h12;
    do_tick(); e2 = 1'b1; expect_now("R5 full match");
    clear_one(2);
    now_min = 8'h16;
    do_tick(); expect_now("R5 minute mismatch");

    // R8 / R9 interrupt gating and routing
    set_a1(8'h80, 8'h80, 8'h80, 8'h80);
    al2_min = 8'h80; al2_hour = 8'h80; al2_daydate = 8'h80;
    do_tick(); e1 = 1'b1; e2 = 1'b1; expect_now("R8 flags without enables");
    al1_int_en = 1'b1;
    idle(2); expect_now("R8 alarm1 enabled shared");
    al1_int_en = 1'b0; al2_int_en = 1'b1;
    idle(2); expect_now("R9 alarm2 on shared pin");
    int_split = 1'b1;
    idle(2); expect_now("R9 alarm2 on own pin");
    al1_int_en = 1'b1;
    idle(2); expect_now("R9 both pins active");
    clear_one(1); expect_now("R8 alarm1 cleared");
    clear_one(2); expect_now("R8 both cleared");

    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule